// File: doc/BRIEF.md
# Boundary Scan Register with Update Latch

This block is a parameterized boundary scan chain for a test access port. Each of its cells holds a capture/shift flip-flop and a parallel update latch. When the instruction decoder selects the chain, a capture strobe loads a snapshot of the pin values into the chain. A shift strobe then moves the chain one place towards the serial output. Bit 0 drives TDO, and TDI enters at the top bit. The shift that moves captured data out also moves new preload data in. An update strobe copies the chain into the update latches. The latches do not change while the chain shifts.

Two mode inputs choose what drives the pins. In the functional mode the core's data and output enable pass straight through. Under EXTEST the update latches drive the pin data. One cell of the chain, at a fixed index, is the output-bus enable control. Under the high-impedance mode the output bus is disabled whatever else is requested. The TAP state machine, the instruction decoder and the pad cells sit outside this block.

Top module: `bsr_chain`

## Requirements
- R1: With `bs_sel_i` high, a clock edge with `capture_dr_i` high loads every chain cell i from `pin_i[i]`.
- R2: With `bs_sel_i` high, a clock edge with `shift_dr_i` high moves chain cell i+1 into cell i and loads `tdi_i` into the top cell (index CHAIN_LEN-1). `tdo_o` always shows cell 0.
- R3: A run of CHAIN_LEN shifts presents the previously captured contents on `tdo_o`, bit 0 first. At the same time it leaves the shifted-in TDI bits in the chain, with the first bit shifted in at index 0.
- R4: The update latches load the whole chain only on a clock edge with `update_dr_i` and `bs_sel_i` both high. At all other times, shifting included, they hold their value.
- R5: With `bs_sel_i` low, the capture, shift and update strobes are ignored, and the chain and the latches keep their contents.
- R6: With `extest_i` high and `hiz_i` low, `pin_data_o` equals the update latches. Otherwise it equals `func_data_i`.
- R7: With `extest_i` high and `hiz_i` low, `bus_oe_o` equals the update latch of cell OE_CELL (default 85). 1 enables the output bus and 0 disables it. With both modes low, `bus_oe_o` follows `func_oe_i`.
- R8: With `hiz_i` high, `bus_oe_o` is 0 whatever the values of `extest_i`, `func_oe_i` and the latches.
- R9: While `rst_ni` is low, the chain and the update latches are 0, so `tdo_o` is 0, and under EXTEST `pin_data_o` is 0 and `bus_oe_o` is 0.
- R10: When `capture_dr_i` and `shift_dr_i` are high on the same edge, the capture takes effect and the shift does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous test-logic reset |
| tdi_i | input | 1 | Serial scan input |
| capture_dr_i | input | 1 | Capture strobe |
| shift_dr_i | input | 1 | Shift strobe |
| update_dr_i | input | 1 | Update strobe |
| bs_sel_i | input | 1 | Boundary-scan instruction selects this chain |
| extest_i | input | 1 | Drive the pins from the update latches |
| hiz_i | input | 1 | Force the output bus to high impedance |
| pin_i | input | CHAIN_LEN | Pin values to capture |
| func_data_i | input | CHAIN_LEN | Functional pin data |
| func_oe_i | input | 1 | Functional output-bus enable |
| tdo_o | output | 1 | Serial scan output (chain cell 0) |
| pin_data_o | output | CHAIN_LEN | Data towards the pins |
| bus_oe_o | output | 1 | Output-bus enable |

## Verification
Three distinct 96-bit patterns are captured, shifted and updated one after another. A fault in a single cell, or a swap between two cells, shows up as a mismatch in the bits that come out. A capture followed by one shift of a lone 1 through otherwise zero data tells the shift direction and the TDI end of the chain apart from the TDO end. A table of mode vectors crosses EXTEST, high impedance, the functional enable and both values of the control cell. It separates which source drives the pins and which input decides the enable. Directed steps cover strobes without selection, a capture and a shift on the same edge, and a reset in the middle of a test.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    MODE_FUNC   = 2'd0,
    MODE_EXTEST = 2'd1,
    MODE_HIZ    = 2'd2
  } pin_mode_e;

  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } dr_op_t;

  // high impedance outranks EXTEST
  function automatic pin_mode_e decode_mode(input logic extest, input logic hiz);
    if (hiz) return MODE_HIZ;
    if (extest) return MODE_EXTEST;
    return MODE_FUNC;
  endfunction

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sel_i,
  input  logic   capture_i,
  input  logic   shift_i,
  input  logic   update_i,
  output dr_op_t op_o
);

  always_comb begin
    op_o         = '0;
    op_o.capture = sel_i & capture_i;
    op_o.shift   = sel_i & shift_i & ~capture_i;  // capture wins (R10)
    op_o.update  = sel_i & update_i;
  end

  p_no_shift_unselected_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> (op_o == '0));

  p_capture_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |-> !op_o.shift);

endmodule

// File: rtl/bsr_cell.sv
module bsr_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic sh_i,
  input  logic upd_i,
  input  logic pin_i,
  input  logic si_i,
  output logic so_o,
  output logic upd_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    so_o <= 1'b0;
    else if (cap_i) so_o <= pin_i;
    else if (sh_i)  so_o <= si_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    upd_q_o <= 1'b0;
    else if (upd_i) upd_q_o <= so_o;
  end

endmodule

// File: rtl/bsr_pin_mux.sv
module bsr_pin_mux
  import bsr_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 96,
  parameter int unsigned OE_CELL   = 85
) (
  input  pin_mode_e             mode_i,
  input  logic [CHAIN_LEN-1:0] upd_q_i,
  input  logic [CHAIN_LEN-1:0] func_data_i,
  input  logic                  func_oe_i,
  output logic [CHAIN_LEN-1:0] pin_data_o,
  output logic                  bus_oe_o
);

  always_comb begin
    unique case (mode_i)
      MODE_EXTEST: begin
        pin_data_o = upd_q_i;
        bus_oe_o   = upd_q_i[OE_CELL];
      end
      MODE_HIZ: begin
        pin_data_o = func_data_i;
        bus_oe_o   = 1'b0;
      end
      default: begin
        pin_data_o = func_data_i;
        bus_oe_o   = func_oe_i;
      end
    endcase
  end

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 96,
  parameter int unsigned OE_CELL   = 85
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tdi_i,
  input  logic                  capture_dr_i,
  input  logic                  shift_dr_i,
  input  logic                  update_dr_i,
  input  logic                  bs_sel_i,
  input  logic                  extest_i,
  input  logic                  hiz_i,
  input  logic [CHAIN_LEN-1:0] pin_i,
  input  logic [CHAIN_LEN-1:0] func_data_i,
  input  logic                  func_oe_i,
  output logic                  tdo_o,
  output logic [CHAIN_LEN-1:0] pin_data_o,
  output logic                  bus_oe_o
);

  localparam int unsigned TOP = CHAIN_LEN - 1;

  dr_op_t                 op;
  pin_mode_e              mode;
  logic [CHAIN_LEN-1:0]  sr_q;
  logic [CHAIN_LEN-1:0]  upd_q;

  bsr_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (bs_sel_i),
    .capture_i (capture_dr_i),
    .shift_i   (shift_dr_i),
    .update_i  (update_dr_i),
    .op_o      (op)
  );

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    logic si;
    if (i == TOP) begin : g_head
      assign si = tdi_i;
    end else begin : g_body
      assign si = sr_q[i+1];
    end
    bsr_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cap_i   (op.capture),
      .sh_i    (op.shift),
      .upd_i   (op.update),
      .pin_i   (pin_i[i]),
      .si_i    (si),
      .so_o    (sr_q[i]),
      .upd_q_o (upd_q[i])
    );
  end

  assign tdo_o = sr_q[0];
  assign mode  = decode_mode(extest_i, hiz_i);

  bsr_pin_mux #(
    .CHAIN_LEN (CHAIN_LEN),
    .OE_CELL   (OE_CELL)
  ) u_mux (
    .mode_i      (mode),
    .upd_q_i     (upd_q),
    .func_data_i (func_data_i),
    .func_oe_i   (func_oe_i),
    .pin_data_o  (pin_data_o),
    .bus_oe_o    (bus_oe_o)
  );

  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_dr_i && bs_sel_i) |=> (sr_q == $past(pin_i)));

  p_shift_head_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_dr_i && bs_sel_i && !capture_dr_i) |=> (sr_q[TOP] == $past(tdi_i)));

  p_shift_tail_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_dr_i && bs_sel_i && !capture_dr_i) |=> (tdo_o == $past(sr_q[1])));

  p_latch_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(update_dr_i && bs_sel_i) |=> $stable(upd_q));

  p_chain_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bs_sel_i |=> $stable(sr_q));

  p_extest_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (extest_i && !hiz_i) |-> (pin_data_o == upd_q));

  p_oe_cell_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (extest_i && !hiz_i) |-> (bus_oe_o == upd_q[OE_CELL]));

  p_hiz_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz_i |-> !bus_oe_o);

endmodule

// File: tb/bsr_chain_tb.sv
module bsr_chain_tb;
  localparam int W  = 96;
  localparam int OE = 85;

  logic clk = 1'b0;
  logic rst_n, tdi, cap, sh, upd, sel, extest, hiz, func_oe;
  logic [W-1:0] pin, func_data;
  logic tdo, bus_oe;
  logic [W-1:0] pin_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  bsr_chain #(.CHAIN_LEN(W), .OE_CELL(OE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tdi_i(tdi), .capture_dr_i(cap),
    .shift_dr_i(sh), .update_dr_i(upd), .bs_sel_i(sel), .extest_i(extest),
    .hiz_i(hiz), .pin_i(pin), .func_data_i(func_data), .func_oe_i(func_oe),
    .tdo_o(tdo), .pin_data_o(pin_data), .bus_oe_o(bus_oe)
  );

  // row: {extest, hiz, func_oe, oe_cell, exp_oe, exp_from_latch}
  localparam logic [5:0] MODE_TBL [8] = '{
    6'b001_0_1_0, 6'b000_1_0_0, 6'b100_1_1_1, 6'b101_0_0_1,
    6'b111_1_0_0, 6'b011_1_0_0, 6'b101_1_1_1, 6'b001_1_1_0
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_capture(input logic [W-1:0] p);
    pin = p; sel = 1'b1; cap = 1'b1;
    tick();
    cap = 1'b0;
  endtask

  task automatic do_shift(input logic [W-1:0] din, output logic [W-1:0] dout);
    sel = 1'b1;
    for (int i = 0; i < W; i++) begin
      dout[i] = tdo;
      tdi = din[i]; sh = 1'b1;
      tick();
    end
    sh = 1'b0;
  endtask

  task automatic do_update;
    sel = 1'b1; upd = 1'b1;
    tick();
    upd = 1'b0;
  endtask

  task automatic load_latch(input logic [W-1:0] p);
    logic [W-1:0] junk;
    do_shift(p, junk);
    do_update();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b, c, d, base, pat1, pat0, out;
    logic cur_oe;
    a    = {3{32'hA5C3_0F96}};
    b    = {32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_3C3C};
    c    = {32'hDEAD_BEEF, 32'h0000_FFFF, 32'h8001_7FFE};
    d    = ~a;
    base = {32'h5A5A_1357, 32'hC0DE_2468, 32'h7777_0001};
    pat1 = base | (W'(1) << OE);
    pat0 = base & ~(W'(1) << OE);

    rst_n = 1'b0; tdi = 0; cap = 0; sh = 0; upd = 0; sel = 0;
    extest = 1'b1; hiz = 0; func_oe = 0; pin = '0; func_data = '1;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 tdo", W'(tdo), W'(0));
    chk("R9 pin_data", pin_data, '0);
    chk("R9 bus_oe", W'(bus_oe), W'(0));
    rst_n = 1'b1;
    tick();

    // R1 R3: capture a, shift b in while a comes out
    do_capture(a);
    chk("R2 tdo after capture", W'(tdo), W'(a[0]));
    do_shift(b, out);
    chk("R1/R3 captured out", out, a);
    do_update();
    chk("R6 latch b", pin_data, b);

    // R4: latches steady while shifting c in; chain held b
    do_shift(c, out);
    chk("R4 latch during shift", pin_data, b);
    chk("R3 chain out", out, b);
    do_update();
    chk("R4 latch update", pin_data, c);

    // R2: direction, single 1 walks from TDI end to TDO
    do_capture(a);
    tdi = 1'b1; sh = 1'b1;
    tick();
    chk("R2 tdo after one shift", W'(tdo), W'(a[1]));
    tdi = 1'b0;
    repeat (W - 2) tick();
    chk("R2 head bit reached tdo", W'(tdo), W'(1));
    sh = 1'b0;
    do_shift(c, out);
    do_update();

    // R5: unselected strobes have no effect
    sel = 1'b0; pin = d; cap = 1'b1; tick(); cap = 1'b0;
    tdi = 1'b1; sh = 1'b1; repeat (5) tick(); sh = 1'b0;
    upd = 1'b1; tick(); upd = 1'b0;
    chk("R5 latch held", pin_data, c);
    do_shift('0, out);
    chk("R5 chain held", out, c);

    // R10: capture and shift on the same edge
    pin = a; sel = 1'b1; cap = 1'b1; sh = 1'b1; tdi = 1'b1;
    tick();
    cap = 1'b0; sh = 1'b0;
    do_shift('0, out);
    chk("R10 capture wins", out, a);

    // R6 R7 R8: mode table
    cur_oe = 1'bx;
    func_data = d;
    foreach (MODE_TBL[k]) begin
      logic [5:0] r;
      r = MODE_TBL[k];
      extest = 1'b0; hiz = 1'b0;
      if (r[2] !== cur_oe) begin
        load_latch(r[2] ? pat1 : pat0);
        cur_oe = r[2];
      end
      extest = r[5]; hiz = r[4]; func_oe = r[3];
      #1;
      chk(r[4] ? "R8 bus_oe" : "R7 bus_oe", W'(bus_oe), W'(r[1]));
      chk("R6 pin_data", pin_data, r[0] ? (cur_oe ? pat1 : pat0) : d);
      @(negedge clk);
    end

    // R9: reset mid-test clears latches and chain
    extest = 1'b1; hiz = 1'b0;
    load_latch(pat1);
    chk("R7 oe before reset", W'(bus_oe), W'(1));
    rst_n = 1'b0;
    #1;
    chk("R9 latch cleared", pin_data, '0);
    chk("R9 tdo cleared", W'(tdo), W'(0));
    chk("R9 bus_oe cleared", W'(bus_oe), W'(0));
    @(negedge clk);
    rst_n = 1'b1;
    tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule